// File: doc/BRIEF.md
# Bit-Flip Injection Campaign Sequencer

This block runs a campaign of upsets in configuration memory. It picks a location inside a programmed window for each step. It asks a frame-rewrite engine to corrupt that location, then hands control to a functional test comparator and waits for the verdict. Depending on the selected policy, it puts the frames back after every test, leaves them corrupted, or lets upsets pile up and cleans them up in batches.

Three policies are available:
- A sequential sweep that undoes every upset.
- Pure accumulation at pseudo-random locations.
- Accumulation with periodic clean-up. An internal record of the outstanding upsets lets the clean-up undo each of them.

A campaign ends when the selected stop condition is met. The conditions are: never, the first observed fault, or a limit on the number of upsets. A sequential sweep also ends when it has covered the whole window. The host reads the done flag, a fault flag and the count of injections.

Random locations come from a 32-bit maximal-length Galois LFSR with polynomial x^32+x^22+x^2+x+1. The LFSR is seeded from a configuration input at campaign start. Its low bits are masked to the smallest all-ones value that covers the upper bound, and any candidate outside the window is rejected.

Top module: `fi_campaign_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `done`, `rw_req`, `tst_start` and `stop_fault` are 0 and `inj_count` is 0.
- R2: With `cfg_mode`=0 (sequential), the flip requests (`rw_op`=0) cover `cfg_lo`, `cfg_lo`+1, … `cfg_hi` in order. The campaign finishes after the location `cfg_hi` has been handled.
- R3: In sequential mode, each test is followed by a restore request (`rw_op`=1) for the address just flipped, before the next flip.
- R4: With `cfg_mode`=1 (accumulation), every flip address lies within [`cfg_lo`,`cfg_hi`] and no restore is ever requested. The address sequence is identical for two campaigns run with the same `cfg_seed`.
- R5: With `cfg_mode`=2 (accumulate and clean up), clean-up happens after `cfg_clean_n` injections, or earlier once LOG_DEPTH upsets are outstanding. At clean-up, every outstanding address is restored, newest first, before the next flip.
- R6: With `cfg_stop`=2, the campaign ends after `cfg_flip_limit` acknowledged flips. With `cfg_stop`=0, it runs until the sequential sweep is complete.
- R7: With `cfg_stop`=1, the campaign ends at the end of the first step that saw either `tst_mismatch` with `tst_done`, or `rw_cfg_err` with the acknowledge of a flip. `stop_fault` then reads 1.
- R8: `rw_req`, `rw_addr` and `rw_op` hold steady until `rw_ack`. One `tst_start` pulse follows each acknowledged flip, and it is never high together with `rw_req`.
- R9: `rw_multi` copies `cfg_multi` during flip requests and is 0 during restore requests.
- R10: `inj_count` counts acknowledged flips since the last `start`. `done` stays high, with no request issued, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a campaign (accepted when idle or done) |
| cfg_mode | input | 2 | 0 sequential, 1 accumulation, 2 accumulate with clean-up |
| cfg_lo | input | ADDR_W | Lowest injectable location |
| cfg_hi | input | ADDR_W | Highest injectable location |
| cfg_clean_n | input | CNT_W | Injections between clean-ups |
| cfg_stop | input | 2 | 0 never, 1 first fault, 2 flip limit |
| cfg_flip_limit | input | CNT_W | Flip limit for stop condition 2 |
| cfg_seed | input | 32 | LFSR seed (0 is replaced by 1) |
| cfg_multi | input | 1 | Request a multi-bit upset per flip |
| rw_req | output | 1 | Request to the frame-rewrite engine |
| rw_op | output | 1 | 0 flip, 1 restore |
| rw_addr | output | ADDR_W | Location of the request |
| rw_multi | output | 1 | Multi-bit upset flag of a flip |
| rw_ack | input | 1 | Request completed |
| rw_cfg_err | input | 1 | Configuration failure, valid with rw_ack |
| tst_start | output | 1 | One-cycle start of a functional test |
| tst_done | input | 1 | Test finished |
| tst_mismatch | input | 1 | Test found a mismatch, valid with tst_done |
| done | output | 1 | Campaign finished |
| stop_fault | output | 1 | A fault was seen in this campaign |
| inj_count | output | CNT_W | Acknowledged flips in this campaign |

## Verification
A wrong sweep pointer or a wrong location choice shows on `rw_addr` at the very next flip request. A wrong undo record shows during the first clean-up, as restore addresses that are missing or in the wrong order. If the test handshake goes wrong, `tst_start` pulses are missing or repeated, and this is visible within one step. Errors in the stop decision show as a `done` that rises one step early or late, with `inj_count` off by the same amount.

// File: rtl/fi_pkg.sv
package fi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SELECT, ST_INJECT, ST_TEST, ST_RESTORE, ST_CHECK, ST_DONE
  } fi_state_e;

  localparam logic [1:0] MODE_SEQ   = 2'd0;
  localparam logic [1:0] MODE_ACCUM = 2'd1;
  localparam logic [1:0] MODE_CLEAN = 2'd2;

  localparam logic [1:0] STOP_NEVER = 2'd0;
  localparam logic [1:0] STOP_FAULT = 2'd1;
  localparam logic [1:0] STOP_COUNT = 2'd2;

  localparam logic OP_FLIP    = 1'b0;
  localparam logic OP_RESTORE = 1'b1;
endpackage

// File: rtl/fi_lfsr32.sv
module fi_lfsr32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        step,
  input  logic [31:0] seed,
  output logic [31:0] value
);
  localparam logic [31:0] TAPS = 32'h8020_0003;

  logic [31:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (load)
      state_d = (seed == 32'd0) ? 32'd1 : seed;
    else if (step)
      state_d = state_q[0] ? ((state_q >> 1) ^ TAPS) : (state_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= 32'd1;
    else        state_q <= state_d;
  end

  assign value = state_q;

  a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 32'd0);
endmodule

// File: rtl/fi_addr_pick.sv
module fi_addr_pick #(
  parameter int ADDR_W = 16
) (
  input  logic              use_random,
  input  logic [31:0]       rnd,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic [ADDR_W-1:0] addr,
  output logic              ok
);
  function automatic logic [ADDR_W-1:0] fill_ones(input logic [ADDR_W-1:0] v);
    logic [ADDR_W-1:0] r;
    r = v;
    for (int s = 1; s < ADDR_W; s = s * 2) r = r | (r >> s);
    return r;
  endfunction

  logic [ADDR_W-1:0] masked;

  always_comb begin
    masked = rnd[ADDR_W-1:0] & fill_ones(hi);
    if (use_random) begin
      addr = masked;
      ok   = (masked >= lo) && (masked <= hi);
    end else begin
      addr = ptr;
      ok   = 1'b1;
    end
  end
endmodule

// File: rtl/fi_undo_stack.sv
module fi_undo_stack #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] din,
  output logic [ADDR_W-1:0] top,
  output logic              full,
  output logic              one_left
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [CW-1:0]     top_idx;

  assign top_idx  = cnt_q - CW'(1);
  assign top      = mem[top_idx[PW-1:0]];
  assign full     = (cnt_q == CW'(DEPTH));
  assign one_left = (cnt_q == CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (push) cnt_d = cnt_q + CW'(1);
    else if (pop)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (push && !clear) mem[cnt_q[PW-1:0]] <= din;
  end

  a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
endmodule

// File: rtl/fi_campaign_seq.sv
module fi_campaign_seq
  import fi_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int LOG_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_mode,
  input  logic [ADDR_W-1:0] cfg_lo,
  input  logic [ADDR_W-1:0] cfg_hi,
  input  logic [CNT_W-1:0]  cfg_clean_n,
  input  logic [1:0]        cfg_stop,
  input  logic [CNT_W-1:0]  cfg_flip_limit,
  input  logic [31:0]       cfg_seed,
  input  logic              cfg_multi,
  output logic              rw_req,
  output logic              rw_op,
  output logic [ADDR_W-1:0] rw_addr,
  output logic              rw_multi,
  input  logic              rw_ack,
  input  logic              rw_cfg_err,
  output logic              tst_start,
  input  logic              tst_done,
  input  logic              tst_mismatch,
  output logic              done,
  output logic              stop_fault,
  output logic [CNT_W-1:0]  inj_count
);
  fi_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d, ptr_q, ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, since_q, since_d;
  logic              fault_q, fault_d, busy_q, busy_d;

  logic              lfsr_load, lfsr_step;
  logic [31:0]       lfsr_val;
  logic [ADDR_W-1:0] pick_addr;
  logic              pick_ok;
  logic              stk_clear, stk_push, stk_pop, stk_full, stk_one;
  logic [ADDR_W-1:0] stk_top;

  logic is_seq, is_clean, clean_due, stop_hit;

  assign is_seq    = (cfg_mode == MODE_SEQ);
  assign is_clean  = (cfg_mode == MODE_CLEAN);
  assign clean_due = is_clean && ((since_q >= cfg_clean_n) || stk_full);
  assign stop_hit  = ((cfg_stop == STOP_FAULT) && fault_q) ||
                     ((cfg_stop == STOP_COUNT) && (cnt_q >= cfg_flip_limit)) ||
                     (is_seq && (ptr_q >= cfg_hi));

  fi_lfsr32 u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(lfsr_load), .step(lfsr_step),
    .seed(cfg_seed), .value(lfsr_val)
  );

  fi_addr_pick #(.ADDR_W(ADDR_W)) u_pick (
    .use_random(!is_seq), .rnd(lfsr_val), .ptr(ptr_q),
    .lo(cfg_lo), .hi(cfg_hi), .addr(pick_addr), .ok(pick_ok)
  );

  fi_undo_stack #(.ADDR_W(ADDR_W), .DEPTH(LOG_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .clear(stk_clear), .push(stk_push),
    .pop(stk_pop), .din(addr_q), .top(stk_top), .full(stk_full),
    .one_left(stk_one)
  );

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    ptr_d     = ptr_q;
    cnt_d     = cnt_q;
    since_d   = since_q;
    fault_d   = fault_q;
    busy_d    = busy_q;
    lfsr_load = 1'b0;
    lfsr_step = 1'b0;
    stk_clear = 1'b0;
    stk_push  = 1'b0;
    stk_pop   = 1'b0;
    rw_req    = 1'b0;
    rw_op     = OP_FLIP;
    rw_addr   = addr_q;
    rw_multi  = 1'b0;
    tst_start = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d   = ST_SELECT;
          lfsr_load = 1'b1;
          stk_clear = 1'b1;
          ptr_d     = cfg_lo;
          cnt_d     = '0;
          since_d   = '0;
          fault_d   = 1'b0;
          busy_d    = 1'b0;
        end
      end
      ST_SELECT: begin
        lfsr_step = 1'b1;
        if (pick_ok) begin
          addr_d  = pick_addr;
          state_d = ST_INJECT;
        end
      end
      ST_INJECT: begin
        rw_req   = 1'b1;
        rw_multi = cfg_multi;
        if (rw_ack) begin
          cnt_d   = cnt_q + CNT_W'(1);
          fault_d = fault_q | rw_cfg_err;
          if (is_clean) begin
            stk_push = !stk_full;
            since_d  = since_q + CNT_W'(1);
          end
          state_d = ST_TEST;
        end
      end
      ST_TEST: begin
        if (!busy_q) begin
          tst_start = 1'b1;
          busy_d    = 1'b1;
        end else if (tst_done) begin
          busy_d  = 1'b0;
          fault_d = fault_q | tst_mismatch;
          state_d = (is_seq || clean_due) ? ST_RESTORE : ST_CHECK;
        end
      end
      ST_RESTORE: begin
        rw_req  = 1'b1;
        rw_op   = OP_RESTORE;
        rw_addr = is_seq ? addr_q : stk_top;
        if (rw_ack) begin
          if (is_seq) begin
            state_d = ST_CHECK;
          end else begin
            stk_pop = 1'b1;
            if (stk_one) begin
              since_d = '0;
              state_d = ST_CHECK;
            end
          end
        end
      end
      ST_CHECK: begin
        if (stop_hit) begin
          state_d = ST_DONE;
        end else begin
          state_d = ST_SELECT;
          if (is_seq) ptr_d = ptr_q + ADDR_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      since_q <= '0;
      fault_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      ptr_q   <= ptr_d;
      cnt_q   <= cnt_d;
      since_q <= since_d;
      fault_q <= fault_d;
      busy_q  <= busy_d;
    end
  end

  assign done       = (state_q == ST_DONE);
  assign stop_fault = fault_q;
  assign inj_count  = cnt_q;

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_req && !rw_ack) |=> (rw_req && $stable(rw_addr) && $stable(rw_op)));
  a_r8_test_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(tst_start && rw_req));
  a_r4_flip_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_req && rw_op == OP_FLIP) |-> (rw_addr >= cfg_lo && rw_addr <= cfg_hi));
  a_r4_accum_no_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_req && cfg_mode == MODE_ACCUM) |-> rw_op == OP_FLIP);
  a_r9_multi_only_flip: assert property (@(posedge clk) disable iff (!rst_n)
    rw_multi |-> (rw_req && rw_op == OP_FLIP));
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_count != $past(inj_count)) |->
      (inj_count == $past(inj_count) + CNT_W'(1) || inj_count == '0));
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rw_req && !tst_start));
endmodule

// File: tb/fi_campaign_seq_test.sv
`timescale 1ns/1ps
module fi_campaign_seq_test;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [1:0] cfg_mode, cfg_stop;
  logic [AW-1:0] cfg_lo, cfg_hi;
  logic [CW-1:0] cfg_clean_n, cfg_flip_limit;
  logic [31:0] cfg_seed;
  logic cfg_multi;
  logic rw_req, rw_op, rw_multi, rw_ack, rw_cfg_err;
  logic [AW-1:0] rw_addr;
  logic tst_start, tst_done, tst_mismatch;
  logic done, stop_fault;
  logic [CW-1:0] inj_count;

  always #2 clk = ~clk;

  fi_campaign_seq #(.ADDR_W(AW), .CNT_W(CW), .LOG_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_clean_n(cfg_clean_n),
    .cfg_stop(cfg_stop), .cfg_flip_limit(cfg_flip_limit), .cfg_seed(cfg_seed),
    .cfg_multi(cfg_multi), .rw_req(rw_req), .rw_op(rw_op), .rw_addr(rw_addr),
    .rw_multi(rw_multi), .rw_ack(rw_ack), .rw_cfg_err(rw_cfg_err),
    .tst_start(tst_start), .tst_done(tst_done), .tst_mismatch(tst_mismatch),
    .done(done), .stop_fault(stop_fault), .inj_count(inj_count)
  );

  int total = 0, bad = 0;
  int nops, nflip, ntest;
  int fail_at, err_at, ack_wait;
  int kind [0:255];
  int oaddr [0:255];
  int omulti [0:255];
  int saved [0:31];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // frame-rewrite engine model: kind 0 flip, 1 restore
  initial begin
    rw_ack = 1'b0;
    rw_cfg_err = 1'b0;
    forever begin
      @(negedge clk);
      if (rw_ack) begin
        rw_ack = 1'b0;
        rw_cfg_err = 1'b0;
      end else if (rw_req) begin
        automatic int a = int'(rw_addr);
        automatic int k = rw_op ? 1 : 0;
        kind[nops] = k; oaddr[nops] = a; omulti[nops] = rw_multi;
        nops++;
        if (k == 0) nflip++;
        for (int w = 0; w < ack_wait; w++) begin
          @(negedge clk);
          chk(rw_req && int'(rw_addr) == a && (rw_op ? 1 : 0) == k, "R8 hold", rw_addr, a);
        end
        rw_ack = 1'b1;
        rw_cfg_err = (k == 0 && nflip == err_at);
      end
    end
  end

  // test comparator model: kind 2
  initial begin
    tst_done = 1'b0;
    tst_mismatch = 1'b0;
    forever begin
      @(negedge clk);
      if (tst_start) begin
        kind[nops] = 2; oaddr[nops] = 0; omulti[nops] = 0;
        nops++;
        ntest++;
        repeat (2) begin
          @(negedge clk);
          chk(!tst_start, "R8 single start", tst_start, 0);
        end
        tst_done = 1'b1;
        tst_mismatch = (ntest == fail_at);
        @(negedge clk);
        tst_done = 1'b0;
        tst_mismatch = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic run();
    nops = 0; nflip = 0; ntest = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 20000 && !done; k++) @(negedge clk);
    chk(done, "R10 done", done, 1);
  endtask

  task automatic setup(input int mode, input int lo, input int hi, input int cn,
                       input int stp, input int lim, input int seed);
    cfg_mode = 2'(mode); cfg_lo = AW'(lo); cfg_hi = AW'(hi);
    cfg_clean_n = CW'(cn); cfg_stop = 2'(stp); cfg_flip_limit = CW'(lim);
    cfg_seed = 32'(seed); cfg_multi = 1'b0;
    fail_at = 0; err_at = 0; ack_wait = 0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    nops = 0; nflip = 0; ntest = 0;
    setup(0, 0, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    chk(!done && !rw_req && !tst_start && !stop_fault && inj_count == 0, "R1 in reset", inj_count, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !rw_req && !tst_start && !stop_fault && inj_count == 0, "R1 after reset", done, 0);

    // sequential sweep 10..17, never stop, multi-bit, slow ack
    setup(0, 10, 17, 0, 0, 0, 1);
    cfg_multi = 1'b1; ack_wait = 3;
    run();
    chk(nops == 24, "R2 op count", nops, 24);
    chk(inj_count == 8, "R10 count", inj_count, 8);
    chk(!stop_fault, "R7 no fault", stop_fault, 0);
    for (int i = 0; i < 8; i++) begin
      chk(kind[3*i] == 0 && oaddr[3*i] == 10 + i, "R2 flip order", oaddr[3*i], 10 + i);
      chk(kind[3*i+1] == 2, "R8 test after flip", kind[3*i+1], 2);
      chk(kind[3*i+2] == 1 && oaddr[3*i+2] == 10 + i, "R3 restore", oaddr[3*i+2], 10 + i);
      chk(omulti[3*i] == 1 && omulti[3*i+2] == 0, "R9 multi flag", omulti[3*i], 1);
    end
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(done && !rw_req && !tst_start, "R10 done held", done, 1);
    end

    // single-location window
    setup(0, 7, 7, 0, 0, 0, 1);
    run();
    chk(nops == 3 && oaddr[0] == 7 && inj_count == 1, "R2 lo==hi", inj_count, 1);

    // flip limit on sequential sweep
    setup(0, 10, 100, 0, 2, 3, 1);
    run();
    chk(inj_count == 3, "R6 limit count", inj_count, 3);
    chk(nops == 9 && oaddr[8] == 12, "R6 last restore", oaddr[8], 12);

    // first functional fault on test 4
    setup(0, 0, 50, 0, 1, 0, 1);
    fail_at = 4;
    run();
    chk(inj_count == 4, "R7 mismatch stop", inj_count, 4);
    chk(stop_fault, "R7 fault flag", stop_fault, 1);
    chk(nops == 12 && kind[11] == 1 && oaddr[11] == 3, "R7 restored before stop", oaddr[11], 3);

    // accumulation, 20 flips, twice with same seed
    setup(1, 5, 40, 0, 2, 20, 32'h1234_5678);
    run();
    chk(inj_count == 20 && nops == 40, "R4 accum ops", nops, 40);
    for (int i = 0; i < 40; i++) begin
      if (i % 2 == 0) begin
        chk(kind[i] == 0 && oaddr[i] >= 5 && oaddr[i] <= 40, "R4 in window", oaddr[i], 5);
        saved[i/2] = oaddr[i];
      end else begin
        chk(kind[i] == 2, "R4 no restore", kind[i], 2);
      end
    end
    run();
    for (int i = 0; i < 20; i++)
      chk(oaddr[2*i] == saved[i], "R4 seed repeat", oaddr[2*i], saved[i]);

    // configuration failure on the second flip
    setup(1, 5, 40, 0, 1, 0, 99);
    err_at = 2;
    run();
    chk(inj_count == 2 && stop_fault && nops == 4, "R7 cfg error stop", inj_count, 2);

    // clean-up every 3 injections, 6 flips
    setup(2, 100, 200, 3, 2, 6, 7);
    run();
    chk(nops == 18 && inj_count == 6, "R5 clean ops", nops, 18);
    for (int b = 0; b < 2; b++) begin
      for (int j = 0; j < 3; j++) begin
        chk(kind[9*b+2*j] == 0 && kind[9*b+2*j+1] == 2, "R5 flip/test", kind[9*b+2*j], 0);
        chk(kind[9*b+6+j] == 1 && oaddr[9*b+6+j] == oaddr[9*b+2*(2-j)],
            "R5 newest first", oaddr[9*b+6+j], oaddr[9*b+2*(2-j)]);
      end
    end

    // clean-up forced by a full record
    setup(2, 100, 200, 20, 2, DEPTH, 11);
    run();
    chk(nops == 3*DEPTH, "R5 full record ops", nops, 3*DEPTH);
    for (int j = 0; j < DEPTH; j++)
      chk(kind[2*DEPTH+j] == 1 && oaddr[2*DEPTH+j] == oaddr[2*(DEPTH-1-j)],
          "R5 full restore", oaddr[2*DEPTH+j], oaddr[2*(DEPTH-1-j)]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule